// File: doc/BRIEF.md
# Atomic Test-and-Set Lock Unit

This unit serves the memory stage of two processor cores and gives them a cheap atomic primitive. A plain load whose address falls in the top sixteen words of the address space does not reach general memory; instead it reads one of sixteen one-word lock cells, hands back the value the cell held, and leaves the cell holding one. The requesting memory stage is held for one extra cycle while this read-modify-write happens. The response arrives in the next cycle, so a core can tell whether it acquired the lock (value zero) or found it taken.

Stores to the same window write the full data word into the addressed cell, which is how software releases a lock or seeds it. The two cores share one access path into the cells: one window access is granted per cycle, ties go round-robin, and while one core's test-and-set is completing the other core cannot touch that cell. A switch hint accompanies every response that returns a nonzero value, so a multithreaded core can treat a busy lock like a cache miss and run another thread.

Top module: `tas_sync_unit`

## Requirements
- R1: Only accesses whose address bits [31:4] are all ones are window accesses; any other access raises no stall, no response and changes no cell.
- R2: There are 16 cells, selected by address bits [3:0]; each cell is written and read independently of the others.
- R3: A granted window load returns the cell's previous full 32-bit value and leaves the cell holding the value 1.
- R4: An uncontested window load stalls its port for exactly one cycle; in the next cycle stall is low and the response valid is high with the returned value.
- R5: A granted window store writes its full 32-bit data into the cell and raises no stall.
- R6: At most one window access is granted per cycle; a port not granted stalls. When both ports want access in the same cycle the priority port wins, priority starts at port 0 after reset and passes to the other port after each contested cycle.
- R7: During the response cycle of one port's load, the other port's access to the same cell stalls; its access to a different cell may be granted in that cycle.
- R8: The switch hint is high in a response cycle exactly when the returned value is nonzero, and low otherwise.
- R9: Reset clears all cells to zero, drives stall, response valid and switch hint low, and gives port 0 priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 2 | Per-port access present (bit p = port p); held while stalled |
| req_write | input | 2 | Per-port store (1) or load (0) |
| req_addr | input | 2x32 | Per-port word address, port p in bits [32p+31:32p] |
| req_wdata | input | 2x32 | Per-port store data |
| stall | output | 2 | Per-port hold request for the memory stage |
| rsp_valid | output | 2 | Per-port load response present |
| rsp_rdata | output | 2x32 | Per-port returned previous cell value |
| switch_hint | output | 2 | Per-port busy-lock hint for thread switching |

## Verification
Every cycle the assertions check that at most one port is granted, that a granted load is answered in the following cycle with the stall already released, that a port is never granted a cell the other port is still completing on, that out-of-window accesses never stall, and that the hint never appears without a response. Whether the returned value is the cell's true previous contents, whether stores actually land in the right cell, the round-robin order across successive contests and the exact stall lengths under collision can only be shown by the bench's scenarios, which compare each response with values worked out from the sequence of accesses.

// File: rtl/tas_sync_pkg.sv
package tas_sync_pkg;
  localparam int TAS_NREQ = 2;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_TAS   = 2'd1,
    OP_STORE = 2'd2
  } op_e;
endpackage

// File: rtl/tas_req_decode.sv
module tas_req_decode
  import tas_sync_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              valid,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  output op_e               op,
  output logic [IDX_W-1:0]  idx
);
  function automatic logic hits_window(input logic [ADDR_W-1:0] a);
    return &a[ADDR_W-1:IDX_W];
  endfunction

  function automatic logic [IDX_W-1:0] cell_of(input logic [ADDR_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction

  always_comb begin
    if (!valid || !hits_window(addr)) op = OP_NONE;
    else if (write)                   op = OP_STORE;
    else                              op = OP_TAS;
    idx = cell_of(addr);
  end
endmodule

// File: rtl/tas_rr_arbiter.sv
module tas_rr_arbiter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] want,
  output logic [1:0] grant
);
  logic prio_q;

  function automatic logic [1:0] pick(input logic [1:0] w, input logic pr);
    if (w == 2'b11) return pr ? 2'b10 : 2'b01;
    return w;
  endfunction

  assign grant = pick(want, prio_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              prio_q <= 1'b0;
    else if (want == 2'b11)  prio_q <= ~prio_q;
  end
endmodule

// File: rtl/tas_lock_array.sv
module tas_lock_array #(
  parameter int NLOCK  = 16,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0][IDX_W-1:0]  rd_idx,
  output logic [1:0][DATA_W-1:0] rd_data,
  input  logic                   we,
  input  logic [IDX_W-1:0]       widx,
  input  logic [DATA_W-1:0]      wdata
);
  logic [DATA_W-1:0] cell_q [NLOCK];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NLOCK; i++) cell_q[i] <= '0;
    end else if (we) begin
      cell_q[widx] <= wdata;
    end
  end

  for (genvar r = 0; r < 2; r++) begin : g_rd
    assign rd_data[r] = cell_q[rd_idx[r]];
  end
endmodule

// File: rtl/tas_sync_unit.sv
module tas_sync_unit
  import tas_sync_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int NLOCK  = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             req_valid,
  input  logic [1:0]             req_write,
  input  logic [1:0][ADDR_W-1:0] req_addr,
  input  logic [1:0][DATA_W-1:0] req_wdata,
  output logic [1:0]             stall,
  output logic [1:0]             rsp_valid,
  output logic [1:0][DATA_W-1:0] rsp_rdata,
  output logic [1:0]             switch_hint
);
  localparam int IDX_W = $clog2(NLOCK);
  localparam logic [DATA_W-1:0] SET_VAL = DATA_W'(1);

  op_e                         req_op [TAS_NREQ];
  logic [1:0][IDX_W-1:0]       req_idx;
  logic [1:0]                  is_tas;
  logic [1:0]                  is_store;
  logic [1:0]                  blocked;
  logic [1:0]                  want;
  logic [1:0]                  grant;
  logic [1:0]                  done_q;
  logic [1:0][IDX_W-1:0]       held_idx;
  logic [1:0][DATA_W-1:0]      old_q;
  logic [1:0][DATA_W-1:0]      cell_rd;
  logic                        wr_en;
  logic [IDX_W-1:0]            wr_idx;
  logic [DATA_W-1:0]           wr_data;

  for (genvar p = 0; p < TAS_NREQ; p++) begin : g_port
    localparam int Q = 1 - p;

    tas_req_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
      .valid (req_valid[p]),
      .write (req_write[p]),
      .addr  (req_addr[p]),
      .op    (req_op[p]),
      .idx   (req_idx[p])
    );

    assign is_tas[p]   = (req_op[p] == OP_TAS);
    assign is_store[p] = (req_op[p] == OP_STORE);
    assign blocked[p]  = done_q[Q] && (held_idx[Q] == req_idx[p]);
    assign want[p]     = (is_tas[p] || is_store[p]) && !done_q[p] && !blocked[p];
    assign stall[p]    = (is_tas[p] || is_store[p]) && !done_q[p]
                         && !(grant[p] && is_store[p]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        done_q[p]   <= 1'b0;
        held_idx[p] <= '0;
        old_q[p]    <= '0;
      end else if (grant[p] && is_tas[p]) begin
        done_q[p]   <= 1'b1;
        held_idx[p] <= req_idx[p];
        old_q[p]    <= cell_rd[p];
      end else begin
        done_q[p]   <= 1'b0;
      end
    end

    assign rsp_valid[p]   = done_q[p];
    assign rsp_rdata[p]   = old_q[p];
    assign switch_hint[p] = done_q[p] && (old_q[p] != '0);
  end

  tas_rr_arbiter u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .want  (want),
    .grant (grant)
  );

  always_comb begin
    wr_en   = |grant;
    wr_idx  = grant[1] ? req_idx[1] : req_idx[0];
    wr_data = grant[1] ? (is_tas[1] ? SET_VAL : req_wdata[1])
                       : (is_tas[0] ? SET_VAL : req_wdata[0]);
  end

  tas_lock_array #(.NLOCK(NLOCK), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_cells (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (req_idx),
    .rd_data (cell_rd),
    .we      (wr_en),
    .widx    (wr_idx),
    .wdata   (wr_data)
  );
endmodule

// File: rtl/tas_sync_checker.sv
module tas_sync_checker #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [1:0]             req_valid,
  input logic [1:0][ADDR_W-1:0] req_addr,
  input logic [1:0]             grant,
  input logic [1:0]             is_tas,
  input logic [1:0]             done_q,
  input logic [1:0][IDX_W-1:0]  held_idx,
  input logic [1:0][IDX_W-1:0]  req_idx,
  input logic [1:0]             stall,
  input logic [1:0]             rsp_valid,
  input logic [1:0]             switch_hint
);
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R6

  for (genvar p = 0; p < 2; p++) begin : g_chk
    localparam int Q = 1 - p;

    AST_TAS_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
      (grant[p] && is_tas[p]) |=> rsp_valid[p]); // R4

    AST_RSP_UNSTALLED: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid[p] |-> !stall[p]); // R4

    AST_RSP_AFTER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid[p] |-> $past(stall[p])); // R4

    AST_CELL_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q[Q] && held_idx[Q] == req_idx[p]) |-> !grant[p]); // R7

    AST_OUTSIDE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[p] && !(&req_addr[p][ADDR_W-1:IDX_W])) |-> !stall[p]); // R1

    AST_HINT_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      switch_hint[p] |-> rsp_valid[p]); // R8
  end
endmodule

bind tas_sync_unit tas_sync_checker #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_addr    (req_addr),
  .grant       (grant),
  .is_tas      (is_tas),
  .done_q      (done_q),
  .held_idx    (held_idx),
  .req_idx     (req_idx),
  .stall       (stall),
  .rsp_valid   (rsp_valid),
  .switch_hint (switch_hint)
);

// File: tb/tas_sync_unit_test.sv
`timescale 1ns/1ps
module tas_sync_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        tb_v [2];
  logic        tb_w [2];
  logic [31:0] tb_a [2];
  logic [31:0] tb_d [2];

  logic [1:0]       req_valid, req_write, stall, rsp_valid, switch_hint;
  logic [1:0][31:0] req_addr, req_wdata, rsp_rdata;

  assign req_valid = {tb_v[1], tb_v[0]};
  assign req_write = {tb_w[1], tb_w[0]};
  assign req_addr  = {tb_a[1], tb_a[0]};
  assign req_wdata = {tb_d[1], tb_d[0]};

  tas_sync_unit uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .stall(stall), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .switch_hint(switch_hint)
  );

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_q0 [$];
  logic [31:0] exp_q1 [$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Monitor: pops the expected value of each response and compares.
  always @(negedge clk) begin
    #2;
    for (int p = 0; p < 2; p++) begin
      if (rst_n && rsp_valid[p]) begin
        logic [31:0] e;
        if ((p == 0 ? exp_q0.size() : exp_q1.size()) == 0) begin
          check(1'b0, "R1", "unexpected response", rsp_rdata[p], 32'h0);
        end else begin
          e = (p == 0) ? exp_q0.pop_front() : exp_q1.pop_front();
          check(rsp_rdata[p] == e, "R3", "returned value", rsp_rdata[p], e);
          check(switch_hint[p] == (e != 0), "R8", "switch hint",
                {31'd0, switch_hint[p]}, {31'd0, e != 0});
        end
      end
    end
  end

  // Driver: window load with expected old value and expected stall cycles.
  task automatic tas(input int p, input int idx, input logic [31:0] exp,
                     input int exp_stall, input string req);
    int n = 0;
    if (p == 0) exp_q0.push_back(exp); else exp_q1.push_back(exp);
    @(negedge clk);
    tb_v[p] = 1'b1; tb_w[p] = 1'b0; tb_a[p] = 32'hFFFF_FFF0 | 32'(idx);
    forever begin
      #1;
      if (stall[p]) begin n++; @(negedge clk); end
      else break;
    end
    @(negedge clk);
    tb_v[p] = 1'b0;
    check(n == exp_stall, req, "load stall cycles", 32'(n), 32'(exp_stall));
  endtask

  task automatic store(input int p, input logic [31:0] addr,
                       input logic [31:0] data, input string req);
    int n = 0;
    @(negedge clk);
    tb_v[p] = 1'b1; tb_w[p] = 1'b1; tb_a[p] = addr; tb_d[p] = data;
    forever begin
      #1;
      if (stall[p]) begin n++; @(negedge clk); end
      else break;
    end
    @(negedge clk);
    tb_v[p] = 1'b0;
    check(n == 0, req, "store stall cycles", 32'(n), 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int p = 0; p < 2; p++) begin
      tb_v[p] = 1'b0; tb_w[p] = 1'b0; tb_a[p] = '0; tb_d[p] = '0;
    end
    repeat (3) @(negedge clk);
    #1;
    check(stall == 2'b00 && rsp_valid == 2'b00 && switch_hint == 2'b00,
          "R9", "outputs in reset", {26'd0, stall, rsp_valid, switch_hint}, 32'h0);
    rst_n = 1'b1;

    // R9 / R2: every cell reads zero after reset and is then set.
    for (int i = 0; i < 16; i++) tas(0, i, 32'h0, 1, "R9");
    // R3 / R4: second load of a cell sees 1.
    tas(1, 5, 32'h1, 1, "R4");

    // R5 / R2: full-word store lands in its own cell only.
    store(1, 32'hFFFF_FFF2, 32'hA5A5_0003, "R5");
    store(0, 32'hFFFF_FFF4, 32'h0000_0044, "R5");
    tas(0, 2, 32'hA5A5_0003, 1, "R5");
    tas(1, 4, 32'h0000_0044, 1, "R2");
    tas(1, 12, 32'h1, 1, "R2");

    // R1: accesses outside the window are ignored.
    store(0, 32'hFFFF_FFE5, 32'h0, "R1");
    @(negedge clk);
    tb_v[1] = 1'b1; tb_w[1] = 1'b0; tb_a[1] = 32'h0000_0006;
    #3;
    check(stall[1] == 1'b0, "R1", "outside load stall", {31'd0, stall[1]}, 32'h0);
    @(negedge clk);
    #3;
    check(rsp_valid[1] == 1'b0, "R1", "outside load rsp", {31'd0, rsp_valid[1]}, 32'h0);
    tb_v[1] = 1'b0;
    tas(0, 5, 32'h1, 1, "R1");

    // R7: other port held off the same cell during the response cycle.
    store(0, 32'hFFFF_FFF3, 32'h0, "R5");
    fork
      tas(0, 3, 32'h0, 1, "R7");
      begin @(negedge clk); tas(1, 3, 32'h1, 2, "R7"); end
    join

    // R6: contested same cell, port 0 first, then port 1.
    store(0, 32'hFFFF_FFF7, 32'h0, "R5");
    store(0, 32'hFFFF_FFF8, 32'h0, "R5");
    store(1, 32'hFFFF_FFF9, 32'h0, "R5");
    store(1, 32'hFFFF_FFFA, 32'h0, "R5");
    fork
      tas(0, 7, 32'h0, 1, "R6");
      tas(1, 7, 32'h1, 3, "R6");
    join
    fork
      tas(1, 8, 32'h0, 1, "R6");
      tas(0, 8, 32'h1, 3, "R6");
    join
    // R6 / R7: contested different cells; loser proceeds during response cycle.
    fork
      tas(0, 9, 32'h0, 1, "R6");
      tas(1, 10, 32'h0, 2, "R7");
    join

    repeat (3) @(negedge clk);
    check(exp_q0.size() == 0 && exp_q1.size() == 0, "R4", "missing responses",
          32'(exp_q0.size() + exp_q1.size()), 32'h0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule